// File: doc/BRIEF.md
# Acquisition Start and Settle-Delay Trigger Controller

This block decides the first sample period in which converter samples may be written into the sample FIFO. Software programs a small trigger configuration word. That word sets the trigger mode and chooses whether the start event comes from a software write strobe or from an external trigger pin. After the start event the block throws away a fixed number of sample periods before it opens the FIFO write gate. In post-trigger mode this is the anti-alias filter latency of 36 periods. In delay-trigger mode it is 72 periods, which lets the converter pipeline settle after a sample-rate change.

A clear strobe stops acquisition, requests a FIFO flush and returns the controller to idle. If the configuration still holds a valid mode, the controller re-arms one cycle later. Once acquisition is running, every `sample_tick` produces one FIFO write enable until the next clear. All control and status pins are plain single-cycle strobes and levels. No sample data passes through this block, so it has no streaming handshake.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `acquiring`, `fifo_wr_en` and `fifo_flush` are 0.
- R2: The configuration word holds the mode in bits 1:0 and the external-trigger enable in bit 4. Mode 2 is post-trigger and mode 3 is delay-trigger. Modes 0 and 1 are disabled, and no start event of either kind begins acquisition while one of them is set.
- R3: In post-trigger mode, after a start the first 36 `sample_tick` pulses give no write enable. The 37th and all later ticks assert `fifo_wr_en`, and `acquiring` first rises in a cycle that follows a tick.
- R4: In delay-trigger mode, after a start the first 72 `sample_tick` pulses give no write enable, and the 73rd tick asserts `fifo_wr_en`.
- R5: With bit 4 set, only a rising edge on `ext_trig` starts acquisition, seen after a two-flop synchroniser, and `sw_start` is ignored. With bit 4 clear, only `sw_start` starts acquisition, and `ext_trig` is ignored.
- R6: While `acquiring` is 1, `fifo_wr_en` equals `sample_tick` in every cycle, and start events have no effect. `fifo_wr_en` is never 1 while `acquiring` is 0.
- R7: Only `clr_strobe` ends acquisition. One cycle after a clear, `acquiring` is 0 and `fifo_flush` is 1 for exactly that cycle. With a valid mode still configured, a later start works again without rewriting the configuration.
- R8: A clear during the discard window abandons the partial count, and the next start discards the full number of ticks again.
- R9: A second start during the discard window does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 5 | Configuration word: bits 1:0 mode, bit 4 external-trigger enable |
| sw_start | input | 1 | Software start write strobe |
| clr_strobe | input | 1 | Clear: flush FIFO, return trigger logic to idle |
| ext_trig | input | 1 | Asynchronous external trigger, acts on rising edge |
| sample_tick | input | 1 | One-cycle pulse per converter sample period |
| acquiring | output | 1 | Acquisition running, FIFO gate open |
| fifo_wr_en | output | 1 | FIFO write enable for the current sample |
| fifo_flush | output | 1 | One-cycle FIFO and flag clear request |

## Verification
The checker tests several rules in every cycle. The write gate never opens outside acquisition or without a tick. Acquisition holds until a clear, and a clear always closes the gate and produces a single flush pulse. Acquisition starts only on a tick, and the reset values hold. The exact discard counts of 36 and 72 ticks can only be shown by the bench's scenarios. The same applies to the mode and trigger-source selection across all combinations, the handling of restart and of clear in the middle of the window, and the re-arming after a clear.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } acq_state_e;

  localparam logic [1:0] MODE_POST  = 2'd2;
  localparam logic [1:0] MODE_DELAY = 2'd3;
  localparam int         CFG_W      = 5;
  localparam int         EXT_EN_BIT = 4;

  typedef struct packed {
    logic       ext_en;
    logic [1:0] mode;
  } trig_cfg_t;
endpackage

// File: rtl/acq_trig_sync.sv
module acq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sr;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      last <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], async_in};
      last <= sr[STAGES-1];
    end
  end

  assign rise = sr[STAGES-1] & ~last;
endmodule

// File: rtl/acq_trig_cfg.sv
module acq_trig_cfg
  import acq_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output trig_cfg_t        cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      cfg.mode   <= wdata[1:0];
      cfg.ext_en <= wdata[EXT_EN_BIT];
    end
  end
endmodule

// File: rtl/acq_trig_settle_cnt.sv
module acq_trig_settle_cnt #(
  parameter int FILTER_TICKS = 36,
  parameter int DELAY_TICKS  = 72
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic use_delay,
  input  logic active,
  input  logic tick,
  output logic done
);
  localparam int MAX_T = (DELAY_TICKS > FILTER_TICKS) ? DELAY_TICKS : FILTER_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(FILTER_TICKS - 1);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DELAY_TICKS - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      last_idx <= '0;
    end else if (load) begin
      cnt      <= '0;
      last_idx <= use_delay ? LAST_D : LAST_F;
    end else if (active && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = active && tick && (cnt == last_idx);
endmodule

// File: rtl/acq_trigger_ctrl.sv
module acq_trigger_ctrl
  import acq_trig_pkg::*;
#(
  parameter int FILTER_TICKS = 36,
  parameter int DELAY_TICKS  = 72,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             sw_start,
  input  logic             clr_strobe,
  input  logic             ext_trig,
  input  logic             sample_tick,
  output logic             acquiring,
  output logic             fifo_wr_en,
  output logic             fifo_flush
);
  trig_cfg_t  cfg;
  acq_state_e state, state_nx;
  logic       ext_rise, start_ev, mode_ok, load, settle_done;

  acq_trig_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  acq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_trig),
    .rise     (ext_rise)
  );

  acq_trig_settle_cnt #(
    .FILTER_TICKS (FILTER_TICKS),
    .DELAY_TICKS  (DELAY_TICKS)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .use_delay (cfg.mode == MODE_DELAY),
    .active    (state == ST_SETTLE),
    .tick      (sample_tick),
    .done      (settle_done)
  );

  assign mode_ok  = (cfg.mode == MODE_POST) || (cfg.mode == MODE_DELAY);
  assign start_ev = cfg.ext_en ? ext_rise : sw_start;
  assign load     = (state == ST_ARMED) && mode_ok && start_ev && !clr_strobe;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (mode_ok) state_nx = ST_ARMED;
      ST_ARMED:  if (!mode_ok) state_nx = ST_IDLE;
                 else if (start_ev) state_nx = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_nx = ST_RUN;
      ST_RUN:    state_nx = ST_RUN;
      default:   state_nx = ST_IDLE;
    endcase
    if (clr_strobe) state_nx = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fifo_flush <= 1'b0;
    end else begin
      state      <= state_nx;
      fifo_flush <= clr_strobe;
    end
  end

  assign acquiring  = (state == ST_RUN);
  assign fifo_wr_en = acquiring && sample_tick;
endmodule

// File: rtl/acq_trigger_checker.sv
module acq_trigger_checker (
  input logic clk,
  input logic rst_n,
  input logic sample_tick,
  input logic clr_strobe,
  input logic acquiring,
  input logic fifo_wr_en,
  input logic fifo_flush
);
  logic seen_clk;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    (seen_clk && !rst_n) |=> (!acquiring && !fifo_wr_en && !fifo_flush))
    else $error("R1 outputs not quiet after reset");

  assert_start_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && $rose(acquiring)) |-> $past(sample_tick))
    else $error("R3 acquisition began without a tick");

  assert_gate_needs_acq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> (acquiring && sample_tick))
    else $error("R6 write enable outside acquisition");

  assert_hold_acq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acquiring && !clr_strobe) |=> acquiring)
    else $error("R7 acquisition ended without clear");

  assert_clear_exits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_strobe |=> (!acquiring && fifo_flush))
    else $error("R7 clear did not stop acquisition or flush");

  assert_flush_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_strobe |=> !fifo_flush)
    else $error("R7 flush without clear");
endmodule

bind acq_trigger_ctrl acq_trigger_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_tick (sample_tick),
  .clr_strobe  (clr_strobe),
  .acquiring   (acquiring),
  .fifo_wr_en  (fifo_wr_en),
  .fifo_flush  (fifo_flush)
);

// File: tb/acq_trigger_ctrl_bench.sv
module acq_trigger_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       sw_start = 1'b0;
  logic       clr_strobe = 1'b0;
  logic       ext_trig = 1'b0;
  logic       sample_tick = 1'b0;
  logic       acquiring, fifo_wr_en, fifo_flush;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  acq_trigger_ctrl u_acq_trigger_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sw_start(sw_start), .clr_strobe(clr_strobe), .ext_trig(ext_trig),
    .sample_tick(sample_tick), .acquiring(acquiring),
    .fifo_wr_en(fifo_wr_en), .fifo_flush(fifo_flush)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int m, input int e);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = {e[0], 2'b00, m[1:0]};
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clear(input string req);
    @(negedge clk); clr_strobe = 1'b1;
    @(negedge clk);
    chk({req, " flush pulse"}, int'(fifo_flush), 1);
    chk({req, " acquiring after clear"}, int'(acquiring), 0);
    clr_strobe = 1'b0;
    @(negedge clk);
    chk({req, " flush single"}, int'(fifo_flush), 0);
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig = 1'b1;
    repeat (4) @(negedge clk);
    ext_trig = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // index of the first tick that produced a write enable, -1 if none
  task automatic run_ticks(input int limit, output int first);
    first = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); sample_tick = 1'b1;
      #1;
      if (fifo_wr_en) first = i;
      @(negedge clk); sample_tick = 1'b0;
      if (first >= 0) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int got;
    int expv;
    repeat (3) @(negedge clk);
    chk("R1 acquiring in reset", int'(acquiring), 0);
    chk("R1 wr_en in reset", int'(fifo_wr_en), 0);
    chk("R1 flush in reset", int'(fifo_flush), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 acquiring after reset", int'(acquiring), 0);

    // sweep: mode x external enable x start source (R2 R3 R4 R5 R7)
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int src = 0; src < 2; src++) begin
          write_cfg(m, e);
          if (src == 0) pulse_sw(); else pulse_ext();
          if (m >= 2 && e == src) expv = (m == 3) ? 72 : 36;
          else expv = -1;
          run_ticks(80, got);
          chk($sformatf("R2/R3/R4/R5 first write tick mode %0d ext %0d src %0d", m, e, src),
              got, expv);
          if (expv >= 0)
            chk("R3 acquiring after gate opens", int'(acquiring), 1);
          else
            chk("R2/R5 start ignored", int'(acquiring), 0);
          do_clear("R7");
        end
      end
    end

    // R9: second start inside discard window does not restart count
    write_cfg(2, 0);
    pulse_sw();
    run_ticks(10, got);
    chk("R9 no write during window", got, -1);
    pulse_sw();
    run_ticks(60, got);
    chk("R9 remaining discard ticks", got, 26);

    // R6: gate follows tick, starts ignored while running
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      sample_tick = (i % 3 == 0);
      sw_start    = (i == 4);
      ext_trig    = (i >= 6);
      #1;
      chk($sformatf("R6 wr_en follows tick cycle %0d", i), int'(fifo_wr_en), int'(sample_tick));
      chk("R6 still acquiring", int'(acquiring), 1);
    end
    @(negedge clk); sample_tick = 1'b0; sw_start = 1'b0; ext_trig = 1'b0;
    do_clear("R7");

    // R8: clear during delay window, then full count again
    write_cfg(3, 0);
    pulse_sw();
    run_ticks(30, got);
    chk("R8 no write in partial window", got, -1);
    do_clear("R8");
    @(negedge clk);
    pulse_sw();
    run_ticks(90, got);
    chk("R8 full delay after clear", got, 72);
    do_clear("R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule